// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block forms the memory address for a single load or store and, when the addressing form calls for it, the new value of the base register. A request carries the base value, an offset that comes either from a zero-extended immediate or from a second register scaled by a left shift, a flag that selects addition or subtraction, one of three indexing forms, and the access size. All address arithmetic is modulo 2^ADDR_W and wraps without any indication.

There are three indexing forms. In the plain-offset form, the access goes to base plus or minus the offset, and the base register is left alone. In the pre-indexed form, the access goes to the same sum, and that sum is also written back to the base register. In the post-indexed form, the access goes to the unmodified base, and the sum is written back afterwards. For halfword and word accesses the block also checks that the access address is naturally aligned, and it raises a fault flag together with the result when it is not. The register file and the memory port are outside the block.

The result appears one clock after the request when `OUT_REG` is 1, which is the default. When `OUT_REG` is 0, the result is combinational.

Top module: `ls_addr_gen`

## Requirements
- R1: With `mode` = 2'b00 (plain offset) or 2'b11 (treated the same way), `acc_addr` is base combined with the offset, `new_base` equals `base_in`, and `wb_en` is 0.
- R2: With `mode` = 2'b01 (pre-indexed), `acc_addr` and `new_base` both equal base combined with the offset, and `wb_en` is 1.
- R3: With `mode` = 2'b10 (post-indexed), `acc_addr` equals the unmodified `base_in`, `new_base` equals base combined with the offset, and `wb_en` is 1.
- R4: With `off_sel` = 0 the offset is `imm_off` zero-extended and `shift_amt` has no effect. With `off_sel` = 1 the offset is `reg_off` shifted left by `shift_amt`, with zeros filled in from the right.
- R5: With `sub` = 0 the offset is added to the base. With `sub` = 1 it is subtracted from the base.
- R6: With `size` = 2'b01 (halfword), `align_fault` is 1 exactly when bit 0 of `acc_addr` is 1.
- R7: With `size` = 2'b10 (word), or 2'b11 (treated as word), `align_fault` is 1 exactly when bits 1:0 of `acc_addr` are not both 0.
- R8: With `size` = 2'b00 (byte), `align_fault` is always 0.
- R9: Sums and differences are taken modulo 2^ADDR_W and wrap silently in both directions.
- R10: With `OUT_REG` = 1, `acc_valid` is 1 in the cycle after a cycle with `req_valid` high, and 0 otherwise. `wb_en` and `align_fault` are 0 whenever `acc_valid` is 0.
- R11: While `rst` is high and in the first cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| base_in | input | ADDR_W | Base register value |
| reg_off | input | ADDR_W | Second register value used as offset |
| imm_off | input | IMM_W | Immediate offset, unsigned |
| off_sel | input | 1 | 0 selects the immediate, 1 selects the shifted register |
| shift_amt | input | SH_W | Left shift applied to the register offset |
| sub | input | 1 | 1 subtracts the offset |
| mode | input | 2 | 00 offset, 01 pre-indexed, 10 post-indexed, 11 as 00 |
| size | input | 2 | 00 byte, 01 halfword, 10 word, 11 as word |
| acc_valid | output | 1 | Result valid |
| acc_addr | output | ADDR_W | Address for the memory access |
| new_base | output | ADDR_W | Value to write back to the base register |
| wb_en | output | 1 | Base writeback requested |
| align_fault | output | 1 | Access address misaligned for its size |

## Verification
The hardest case to reach is a post-indexed access whose alignment verdict differs from the verdict for the written-back sum. Stimulus for this case uses an aligned base with an odd offset, and a misaligned base with an offset that would realign it. This shows that the fault check looks at the address actually used and not at the sum. Wrap-around cases are driven directly: a base near 2^32 plus a positive step, and a small base minus a larger step. A register offset with a large shift, where bits are pushed off the top, completes the stimulus.

// File: rtl/ls_addr_gen_pkg.sv
package ls_addr_gen_pkg;
  typedef enum logic [1:0] {
    IDX_OFFSET = 2'b00,
    IDX_PRE    = 2'b01,
    IDX_POST   = 2'b10,
    IDX_RSVD   = 2'b11
  } idx_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/ls_off_unit.sv
module ls_off_unit #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  localparam int SH_W  = $clog2(ADDR_W)
) (
  input  logic [ADDR_W-1:0] reg_off,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic              off_sel,
  input  logic [SH_W-1:0]   shift_amt,
  output logic [ADDR_W-1:0] offset
);
  logic [ADDR_W-1:0] imm_ext;
  logic [ADDR_W-1:0] reg_shifted;

  generate
    if (IMM_W >= ADDR_W) begin : g_imm_trunc
      assign imm_ext = imm_off[ADDR_W-1:0];
    end else begin : g_imm_zext
      assign imm_ext = {{(ADDR_W-IMM_W){1'b0}}, imm_off};
    end
  endgenerate

  assign reg_shifted = reg_off << shift_amt;

  always_comb begin
    offset = off_sel ? reg_shifted : imm_ext;
  end
endmodule

// File: rtl/ls_sum_unit.sv
module ls_sum_unit
  import ls_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] offset,
  input  logic              sub,
  input  idx_mode_e         mode,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] nbase,
  output logic              wb
);
  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum = sub ? (base_in - offset) : (base_in + offset);
    case (mode)
      IDX_PRE: begin
        addr  = sum;
        nbase = sum;
        wb    = 1'b1;
      end
      IDX_POST: begin
        addr  = base_in;
        nbase = sum;
        wb    = 1'b1;
      end
      default: begin
        addr  = sum;
        nbase = base_in;
        wb    = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ls_align_chk.sv
module ls_align_chk
  import ls_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  acc_size_e         size,
  output logic              fault
);
  always_comb begin
    case (size)
      SZ_BYTE: fault = 1'b0;
      SZ_HALF: fault = addr[0];
      default: fault = |addr[1:0];
    endcase
  end
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_addr_gen_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 12,
  parameter bit OUT_REG = 1'b1,
  localparam int SH_W   = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] reg_off,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic              off_sel,
  input  logic [SH_W-1:0]   shift_amt,
  input  logic              sub,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  output logic              acc_valid,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] new_base,
  output logic              wb_en,
  output logic              align_fault
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] c_addr;
  logic [ADDR_W-1:0] c_nbase;
  logic              c_wb;
  logic              c_fault;

  ls_off_unit #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_off (
    .reg_off   (reg_off),
    .imm_off   (imm_off),
    .off_sel   (off_sel),
    .shift_amt (shift_amt),
    .offset    (offset)
  );

  ls_sum_unit #(.ADDR_W(ADDR_W)) u_sum (
    .base_in (base_in),
    .offset  (offset),
    .sub     (sub),
    .mode    (idx_mode_e'(mode)),
    .addr    (c_addr),
    .nbase   (c_nbase),
    .wb      (c_wb)
  );

  ls_align_chk #(.ADDR_W(ADDR_W)) u_align (
    .addr  (c_addr),
    .size  (acc_size_e'(size)),
    .fault (c_fault)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          acc_valid   <= 1'b0;
          acc_addr    <= '0;
          new_base    <= '0;
          wb_en       <= 1'b0;
          align_fault <= 1'b0;
        end else begin
          acc_valid   <= req_valid;
          acc_addr    <= c_addr;
          new_base    <= c_nbase;
          wb_en       <= req_valid & c_wb;
          align_fault <= req_valid & c_fault;
        end
      end
    end else begin : g_comb
      always_comb begin
        acc_valid   = req_valid & ~rst;
        acc_addr    = rst ? '0 : c_addr;
        new_base    = rst ? '0 : c_nbase;
        wb_en       = req_valid & ~rst & c_wb;
        align_fault = req_valid & ~rst & c_fault;
      end
    end
  endgenerate
endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk #(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 12,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] base_in,
  input logic [1:0]        mode,
  input logic [1:0]        size,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [ADDR_W-1:0] new_base,
  input logic              wb_en,
  input logic              align_fault
);
  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> (!wb_en && !align_fault)); // R10

  AST_HALF_FAULT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && $past(size) == 2'b01) |-> (align_fault == acc_addr[0])); // R6

  AST_WORD_FAULT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && $past(size[1])) |-> (align_fault == (acc_addr[1:0] != 2'b00))); // R7

  AST_BYTE_NOFAULT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && $past(size) == 2'b00) |-> !align_fault); // R8

  generate
    if (OUT_REG) begin : g_seq
      AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> acc_valid); // R10

      AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (mode == 2'b00 || mode == 2'b11)) |=>
          (!wb_en && new_base == $past(base_in))); // R1

      AST_PRE_SAME: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 2'b01) |=> (wb_en && acc_addr == new_base)); // R2

      AST_POST_BASE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode == 2'b10) |=> (wb_en && acc_addr == $past(base_in))); // R3
    end
  endgenerate
endmodule

bind ls_addr_gen ls_addr_gen_chk #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .base_in     (base_in),
  .mode        (mode),
  .size        (size),
  .acc_valid   (acc_valid),
  .acc_addr    (acc_addr),
  .new_base    (new_base),
  .wb_en       (wb_en),
  .align_fault (align_fault)
);

// File: tb/test_ls_addr_gen.sv
module test_ls_addr_gen;
  localparam int ADDR_W = 32;
  localparam int IMM_W  = 12;
  localparam int SH_W   = $clog2(ADDR_W);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] base_in = '0;
  logic [ADDR_W-1:0] reg_off = '0;
  logic [IMM_W-1:0]  imm_off = '0;
  logic              off_sel = 1'b0;
  logic [SH_W-1:0]   shift_amt = '0;
  logic              sub = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic [1:0]        size = 2'b00;
  logic              acc_valid;
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] new_base;
  logic              wb_en;
  logic              align_fault;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ls_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) i_ls_addr_gen (
    .clk (clk), .rst (rst), .req_valid (req_valid), .base_in (base_in),
    .reg_off (reg_off), .imm_off (imm_off), .off_sel (off_sel),
    .shift_amt (shift_amt), .sub (sub), .mode (mode), .size (size),
    .acc_valid (acc_valid), .acc_addr (acc_addr), .new_base (new_base),
    .wb_en (wb_en), .align_fault (align_fault)
  );

  task automatic chk(input string req, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request, checked a cycle later; expected values from the requirements
  task automatic run(input string req, input logic [31:0] b, input logic [31:0] r,
                     input logic [11:0] im, input logic os, input logic [4:0] sh,
                     input logic sb, input logic [1:0] md, input logic [1:0] sz);
    logic [31:0] off, sum, ea, nb;
    logic        wb, flt;
    off = os ? (r << sh) : {20'h0, im};
    sum = sb ? b - off : b + off;
    ea  = (md == 2'b10) ? b : sum;
    nb  = (md == 2'b01 || md == 2'b10) ? sum : b;
    wb  = (md == 2'b01 || md == 2'b10);
    flt = (sz == 2'b00) ? 1'b0 : (sz == 2'b01) ? ea[0] : (ea[1:0] != 2'b00);
    @(negedge clk);
    req_valid = 1'b1; base_in = b; reg_off = r; imm_off = im; off_sel = os;
    shift_amt = sh; sub = sb; mode = md; size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, {31'h0, acc_valid}, 32'h1);
    chk({req, " addr"},  acc_addr, ea);
    chk({req, " base"},  new_base, nb);
    chk({req, " wb"},    {31'h0, wb_en}, {31'h0, wb});
    chk({req, " fault"}, {31'h0, align_fault}, {31'h0, flt});
  endtask

  task automatic t_reset;
    chk("R11 valid", {31'h0, acc_valid}, 32'h0);
    chk("R11 addr", acc_addr, 32'h0);
    chk("R11 base", new_base, 32'h0);
    chk("R11 wb", {31'h0, wb_en}, 32'h0);
    chk("R11 fault", {31'h0, align_fault}, 32'h0);
  endtask

  task automatic t_modes;
    run("R1 offset imm",   32'h0000_1000, 32'h0, 12'd8,  1'b0, 5'd0, 1'b0, 2'b00, 2'b10);
    run("R1 reserved md",  32'h0000_2000, 32'h0, 12'd12, 1'b0, 5'd0, 1'b0, 2'b11, 2'b10);
    run("R2 pre imm",      32'h0000_1000, 32'h0, 12'd12, 1'b0, 5'd0, 1'b0, 2'b01, 2'b10);
    run("R3 post neg",     32'h0000_1000, 32'h0, 12'd4,  1'b0, 5'd0, 1'b1, 2'b10, 2'b10);
  endtask

  task automatic t_offsets;
    run("R4 reg shl2",     32'h0000_0100, 32'd5, 12'd0, 1'b1, 5'd2, 1'b0, 2'b00, 2'b10);
    run("R4 imm ign shift",32'h0000_0100, 32'd9, 12'd3, 1'b0, 5'd7, 1'b0, 2'b00, 2'b00);
    run("R4 big shift",    32'h0000_0000, 32'hFFFF_FFFF, 12'd0, 1'b1, 5'd31, 1'b0, 2'b01, 2'b00);
    run("R5 sub reg",      32'h0000_0100, 32'd3, 12'd0, 1'b1, 5'd1, 1'b1, 2'b01, 2'b01);
  endtask

  task automatic t_align;
    run("R6 half odd",     32'h0000_0101, 32'h0, 12'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b01);
    run("R6 half even",    32'h0000_0102, 32'h0, 12'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b01);
    run("R7 word two",     32'h0000_0100, 32'h0, 12'd2, 1'b0, 5'd0, 1'b0, 2'b01, 2'b10);
    run("R7 word rsvd sz", 32'h0000_0103, 32'h0, 12'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b11);
    run("R7 post odd off", 32'h0000_0100, 32'h0, 12'd1, 1'b0, 5'd0, 1'b0, 2'b10, 2'b10);
    run("R7 post misbase", 32'h0000_0103, 32'h0, 12'd1, 1'b0, 5'd0, 1'b0, 2'b10, 2'b10);
    run("R8 byte odd",     32'h0000_0103, 32'h0, 12'd0, 1'b0, 5'd0, 1'b0, 2'b01, 2'b00);
  endtask

  task automatic t_wrap;
    run("R9 wrap up",      32'hFFFF_FFFC, 32'h0, 12'd8, 1'b0, 5'd0, 1'b0, 2'b01, 2'b10);
    run("R9 wrap down",    32'h0000_0004, 32'h0, 12'd8, 1'b0, 5'd0, 1'b1, 2'b10, 2'b10);
  endtask

  task automatic t_idle;
    @(negedge clk);
    mode = 2'b01; size = 2'b10; imm_off = 12'd1; req_valid = 1'b0;
    @(negedge clk);
    chk("R10 idle valid", {31'h0, acc_valid}, 32'h0);
    chk("R10 idle wb", {31'h0, wb_en}, 32'h0);
    chk("R10 idle fault", {31'h0, align_fault}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_modes();
    t_offsets();
    t_align();
    t_wrap();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule